// File: doc/BRIEF.md
# Direct-Page Effective Address Generator

This block produces the bank-zero byte addresses for a direct-page memory access in a 16-bit core that can also run in 8-bit emulation mode. When an access starts, it captures the direct register, the emulation flag, an 8-bit operand offset, a 16-bit index value and an addressing class. It then issues one 24-bit address per byte of the access. A plain 8-bit access has one byte. A 16-bit access or an indirect push has two. A long-pointer fetch has three.

Addresses are formed in one of two ways. The full rule adds the direct register, the offset, the index and the byte number modulo 65536. The page-confined rule keeps the upper byte of the direct register and wraps only the low byte. The page-confined rule applies only to the plain and indexed classes, only in emulation mode, and only when the low byte of the direct register is zero. The long-pointer and indirect-push classes always use the full rule, so a pointer that starts at page offset FE or FF carries into the next page.

The generator is driven by a one-cycle start strobe. Each address is presented with a valid flag and held until the consumer raises ready. A one-cycle finish pulse follows the final byte.

Top module: `dpage_addr_gen`

## Requirements
- R1: After reset, `valid_o` and `done_o` are low and `addr_o` is 000000.
- R2: A `start_i` seen while `valid_o` is low makes `valid_o` high in the next cycle, with the address of byte 0. A `start_i` seen while `valid_o` is high has no effect on the access in progress.
- R3: Byte counts depend on `mode_i`: 0 = plain, 1 = indexed, 2 = long pointer, 3 = indirect push. Mode 2 issues 3 bytes and mode 3 issues 2. Modes 0 and 1 issue 2 bytes when `wide_i` is 1 and 1 byte when it is 0.
- R4: In native mode (`emu_i` = 0), byte k is at (D + offset + k) mod 65536. In mode 1 the index is also added into that sum.
- R5: In emulation mode with D[7:0] = 00, modes 0 and 1 address {D[15:8], low byte of (offset [+ index] + k)}. The address never leaves the page, including the second byte of a 16-bit access.
- R6: In emulation mode with D[7:0] not equal to 00, all modes use the full rule of R4.
- R7: Modes 2 and 3 use the full rule even in emulation mode. With D = 0000 and offset FF, the bytes are at 0000FF then 000100, which is the stack page.
- R8: While `valid_o` is high and `ready_i` is low, `addr_o` and `valid_o` hold.
- R9: `done_o` is high for exactly one cycle. It comes in the cycle after the last byte is accepted and is never high together with `valid_o`.
- R10: D, E, offset, index, mode and width are captured on the accepted start. Changes to them later in the access do not change its addresses.
- R11: Bits [23:16] of `addr_o` are always 00 while `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an access (accepted when idle) |
| dreg_i | input | 16 | Direct register D |
| emu_i | input | 1 | Emulation-mode flag |
| ofs_i | input | 8 | Operand offset |
| idx_i | input | 16 | Index value (used by mode 1) |
| mode_i | input | 2 | Addressing class: 0 plain, 1 indexed, 2 long pointer, 3 indirect push |
| wide_i | input | 1 | 16-bit access for modes 0 and 1 |
| ready_i | input | 1 | Consumer accepts the current address |
| addr_o | output | 24 | Byte address |
| valid_o | output | 1 | `addr_o` is valid |
| done_o | output | 1 | One-cycle pulse after the final byte |

## Verification
The bench targets four corners.

- **Offset at FE or FF in emulation mode with D = 0000, modes 2 and 3.** A design that confined these fetches to the page would return to 000000 instead of reaching 000100.
- **16-bit plain access at offset FF with D = 1200.** A design that forgot to confine the second byte would emit 001300 instead of 001200.
- **Emulation mode with a non-zero D low byte.** A design that tested only the emulation flag would wrongly wrap here.
- **Native sums beyond FFFF.** A design with a wrong carry would leak into the bank byte.

Random stalls on `ready_i`, stray start pulses and input changes during an access expose a generator that advances without a handshake or reads live inputs instead of the captured ones.

// File: rtl/dpage_pkg.sv
package dpage_pkg;
   typedef enum logic [1:0] {
      DP_PLAIN    = 2'd0,
      DP_INDEXED  = 2'd1,
      DP_PTR_LONG = 2'd2,
      DP_PUSH_IND = 2'd3
   } dp_class_e;

   function automatic logic page_confined_class(input dp_class_e c);
      return (c == DP_PLAIN) || (c == DP_INDEXED);
   endfunction
endpackage

// File: rtl/dpage_len_dec.sv
module dpage_len_dec
   import dpage_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  dp_class_e        cls_i,
   input  logic             wide_i,
   output logic [CNT_W-1:0] len_o
);
   always_comb begin
      unique case (cls_i)
         DP_PTR_LONG: len_o = CNT_W'(3);
         DP_PUSH_IND: len_o = CNT_W'(2);
         default:     len_o = wide_i ? CNT_W'(2) : CNT_W'(1);
      endcase
   end
endmodule

// File: rtl/dpage_addr_calc.sv
module dpage_addr_calc
   import dpage_pkg::*;
#(
   parameter int DR_W   = 16,
   parameter int PG_W   = 8,
   parameter int BANK_W = 8,
   parameter int CNT_W  = 2,
   localparam int AW    = BANK_W + DR_W
) (
   input  logic [DR_W-1:0]  dreg_i,
   input  logic             emu_i,
   input  dp_class_e        cls_i,
   input  logic [DR_W-1:0]  sum_i,
   input  logic [CNT_W-1:0] step_i,
   output logic [AW-1:0]    addr_o
);
   logic [DR_W-1:0] tot;
   logic [DR_W-1:0] full_ea;
   logic            confine;

   assign tot     = sum_i + DR_W'(step_i);
   assign full_ea = dreg_i + tot;
   assign confine = emu_i && (dreg_i[PG_W-1:0] == '0) && page_confined_class(cls_i);

   generate
      if (BANK_W > 0) begin : g_bank
         always_comb begin
            if (confine) addr_o = {{BANK_W{1'b0}}, dreg_i[DR_W-1:PG_W], tot[PG_W-1:0]};
            else         addr_o = {{BANK_W{1'b0}}, full_ea};
         end
      end else begin : g_nobank
         always_comb begin
            if (confine) addr_o = {dreg_i[DR_W-1:PG_W], tot[PG_W-1:0]};
            else         addr_o = full_ea;
         end
      end
   endgenerate
endmodule

// File: rtl/dpage_step_ctl.sv
module dpage_step_ctl #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             ready_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             valid_o,
   output logic             done_o,
   output logic             load_o,
   output logic             upd_o,
   output logic [CNT_W-1:0] step_nxt_o
);
   logic [CNT_W-1:0] step_q, len_q;
   logic             adv, last;

   assign load_o = start_i && !valid_o;
   assign adv    = valid_o && ready_i;
   assign last   = (step_q == len_q - CNT_W'(1));
   assign upd_o  = load_o || (adv && !last);

   always_comb begin
      if (load_o)            step_nxt_o = '0;
      else if (adv && !last) step_nxt_o = step_q + CNT_W'(1);
      else                   step_nxt_o = step_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         done_o  <= 1'b0;
         step_q  <= '0;
         len_q   <= '0;
      end else begin
         step_q <= step_nxt_o;
         if (load_o) begin
            valid_o <= 1'b1;
            done_o  <= 1'b0;
            len_q   <= len_i;
         end else if (adv && last) begin
            valid_o <= 1'b0;
            done_o  <= 1'b1;
         end else begin
            done_o  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dpage_addr_gen.sv
module dpage_addr_gen
   import dpage_pkg::*;
#(
   parameter int DR_W    = 16,
   parameter int OFS_W   = 8,
   parameter int IDX_W   = 16,
   parameter int PG_W    = 8,
   parameter int BANK_W  = 8,
   parameter int MAX_LEN = 3,
   localparam int CNT_W  = $clog2(MAX_LEN + 1),
   localparam int AW     = BANK_W + DR_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [DR_W-1:0]  dreg_i,
   input  logic             emu_i,
   input  logic [OFS_W-1:0] ofs_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [1:0]       mode_i,
   input  logic             wide_i,
   input  logic             ready_i,
   output logic [AW-1:0]    addr_o,
   output logic             valid_o,
   output logic             done_o
);
   generate
      if (MAX_LEN < 3)     begin : g_chk_len  $error("MAX_LEN must cover a 3-byte pointer"); end
      if (OFS_W > DR_W)    begin : g_chk_ofs  $error("offset wider than direct register"); end
      if (IDX_W > DR_W)    begin : g_chk_idx  $error("index wider than direct register"); end
      if (PG_W >= DR_W)    begin : g_chk_pg   $error("page must be narrower than direct register"); end
   endgenerate

   dp_class_e        cls_in, cls_q, cls_nxt;
   logic [DR_W-1:0]  sum_in, sum_q, sum_nxt;
   logic [DR_W-1:0]  dreg_q, dreg_nxt;
   logic             emu_q, emu_nxt;
   logic [CNT_W-1:0] len_in, step_nxt;
   logic             load, upd;
   logic [AW-1:0]    addr_nxt;

   assign cls_in = dp_class_e'(mode_i);
   assign sum_in = DR_W'(ofs_i) + ((cls_in == DP_INDEXED) ? DR_W'(idx_i) : '0);

   dpage_len_dec #(.CNT_W(CNT_W)) u_len (
      .cls_i (cls_in),
      .wide_i(wide_i),
      .len_o (len_in)
   );

   dpage_step_ctl #(.CNT_W(CNT_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .ready_i   (ready_i),
      .len_i     (len_in),
      .valid_o   (valid_o),
      .done_o    (done_o),
      .load_o    (load),
      .upd_o     (upd),
      .step_nxt_o(step_nxt)
   );

   assign dreg_nxt = load ? dreg_i : dreg_q;
   assign emu_nxt  = load ? emu_i  : emu_q;
   assign cls_nxt  = load ? cls_in : cls_q;
   assign sum_nxt  = load ? sum_in : sum_q;

   dpage_addr_calc #(.DR_W(DR_W), .PG_W(PG_W), .BANK_W(BANK_W), .CNT_W(CNT_W)) u_calc (
      .dreg_i(dreg_nxt),
      .emu_i (emu_nxt),
      .cls_i (cls_nxt),
      .sum_i (sum_nxt),
      .step_i(step_nxt),
      .addr_o(addr_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dreg_q <= '0;
         emu_q  <= 1'b0;
         cls_q  <= DP_PLAIN;
         sum_q  <= '0;
         addr_o <= '0;
      end else begin
         if (load) begin
            dreg_q <= dreg_i;
            emu_q  <= emu_i;
            cls_q  <= cls_in;
            sum_q  <= sum_in;
         end
         if (upd) addr_o <= addr_nxt;
      end
   end
endmodule

// File: rtl/dpage_addr_gen_chk.sv
module dpage_addr_gen_chk #(
   parameter int DR_W   = 16,
   parameter int PG_W   = 8,
   parameter int BANK_W = 8,
   localparam int AW    = BANK_W + DR_W
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic [DR_W-1:0] dreg_i,
   input logic            emu_i,
   input logic [1:0]      mode_i,
   input logic            ready_i,
   input logic [AW-1:0]   addr_o,
   input logic            valid_o,
   input logic            done_o
);
   logic [2:0]           bcnt;
   logic                 ck_long, ck_wrap;
   logic [DR_W-PG_W-1:0] ck_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt <= '0; ck_long <= 1'b0; ck_wrap <= 1'b0; ck_hi <= '0;
      end else if (start_i && !valid_o) begin
         bcnt    <= '0;
         ck_long <= mode_i[1];
         ck_wrap <= emu_i && (dreg_i[PG_W-1:0] == '0) && !mode_i[1];
         ck_hi   <= dreg_i[DR_W-1:PG_W];
      end else if (valid_o && ready_i) begin
         bcnt <= bcnt + 3'd1;
      end
   end

   AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !valid_o) |=> valid_o); // R2
   AST_MAX_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (bcnt < 3'd3)); // R3
   AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ck_wrap) |-> (addr_o[DR_W-1:PG_W] == ck_hi)); // R5
   AST_LONG_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ready_i && ck_long) |=> (!valid_o || addr_o[DR_W-1:0] == $past(addr_o[DR_W-1:0]) + DR_W'(1))); // R7
   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(addr_o))); // R8
   AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !valid_o); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
   AST_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (addr_o[AW-1:DR_W] == '0)); // R11
endmodule

bind dpage_addr_gen dpage_addr_gen_chk #(.DR_W(DR_W), .PG_W(PG_W), .BANK_W(BANK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .dreg_i(dreg_i), .emu_i(emu_i),
   .mode_i(mode_i), .ready_i(ready_i), .addr_o(addr_o), .valid_o(valid_o), .done_o(done_o)
);

// File: tb/tb_dpage_addr_gen.sv
module tb_dpage_addr_gen;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_LIMIT = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] dreg_i = '0;
   logic        emu_i = 1'b0;
   logic [7:0]  ofs_i = '0;
   logic [15:0] idx_i = '0;
   logic [1:0]  mode_i = '0;
   logic        wide_i = 1'b0;
   logic        ready_i = 1'b0;
   logic [23:0] addr_o;
   logic        valid_o, done_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dpage_addr_gen dut (.*);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WDOG_LIMIT) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, WDOG_LIMIT);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: act=%06h exp=%06h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] ref_addr(input logic [15:0] d, input bit e, input logic [7:0] o,
                                            input logic [15:0] x, input logic [1:0] m, input int k);
      logic [15:0] s;
      s = {8'h00, o} + ((m == 2'd1) ? x : 16'h0000) + 16'(k);
      if (e && d[7:0] == 8'h00 && m < 2'd2) return {8'h00, d[15:8], s[7:0]};
      return {8'h00, 16'(d + s)};
   endfunction

   function automatic string tag_of(input logic [15:0] d, input bit e, input logic [1:0] m);
      if (m >= 2'd2) return "R7";
      if (!e) return "R4";
      if (d[7:0] == 8'h00) return "R5";
      return "R6";
   endfunction

   task automatic do_access(input logic [15:0] d, input bit e, input logic [7:0] o, input logic [15:0] x,
                            input logic [1:0] m, input bit w, input bit noisy);
      int n;
      logic [23:0] held;
      n = (m == 2'd2) ? 3 : (m == 2'd3) ? 2 : (w ? 2 : 1);
      dreg_i = d; emu_i = e; ofs_i = o; idx_i = x; mode_i = m; wide_i = w;
      start_i = 1'b1; ready_i = 1'b0;
      @(posedge clk); @(negedge clk);
      start_i = 1'b0;
      chk(valid_o === 1'b1, "R2 valid after start", 32'(valid_o), 32'd1);
      for (int k = 0; k < n; k++) begin
         if (noisy) begin   // R10: live inputs change mid-access
            dreg_i = 16'($urandom); emu_i = 1'($urandom); ofs_i = 8'($urandom);
            idx_i = 16'($urandom); mode_i = 2'($urandom); wide_i = 1'($urandom);
         end
         if ($urandom_range(0, 2) == 0) begin
            held = addr_o;
            if (noisy) start_i = 1'b1;   // R2: stray start while busy
            @(posedge clk); @(negedge clk);
            start_i = 1'b0;
            chk(valid_o === 1'b1 && addr_o === held, "R8 hold on stall", {8'h0, addr_o}, {8'h0, held});
         end
         chk(addr_o === ref_addr(d, e, o, x, m, k),
             noisy ? {tag_of(d, e, m), "/R10 byte addr"} : {tag_of(d, e, m), " byte addr"},
             {8'h0, addr_o}, {8'h0, ref_addr(d, e, o, x, m, k)});
         chk(addr_o[23:16] === 8'h00, "R11 bank zero", {24'h0, addr_o[23:16]}, 32'h0);
         ready_i = 1'b1;
         @(posedge clk); @(negedge clk);
         ready_i = 1'b0;
         if (k < n - 1)
            chk(valid_o === 1'b1, "R3 more bytes", 32'(valid_o), 32'd1);
         else
            chk(valid_o === 1'b0 && done_o === 1'b1, "R3/R9 end of access", {30'h0, valid_o, done_o}, 32'h1);
      end
      @(posedge clk); @(negedge clk);
      chk(done_o === 1'b0 && valid_o === 1'b0, "R9 single pulse", {30'h0, valid_o, done_o}, 32'h0);
   endtask

   initial begin
      void'($urandom(32'h5EED_0816));
      repeat (3) @(negedge clk);
      chk(valid_o === 1'b0 && done_o === 1'b0 && addr_o === 24'h0, "R1 reset state",
          {6'h0, valid_o, done_o, addr_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(valid_o === 1'b0 && done_o === 1'b0 && addr_o === 24'h0, "R1 idle after reset",
          {6'h0, valid_o, done_o, addr_o}, 32'h0);

      // directed corners
      do_access(16'h0000, 1'b1, 8'hFF, 16'h0, 2'd3, 1'b0, 1'b0);   // R7 push: 0000FF, 000100
      do_access(16'h0000, 1'b1, 8'hFE, 16'h0, 2'd2, 1'b0, 1'b0);   // R7 long: FE, FF, 100
      do_access(16'h0000, 1'b1, 8'hFF, 16'h0, 2'd2, 1'b0, 1'b0);   // R7 long from FF
      do_access(16'h1200, 1'b1, 8'hFF, 16'h0, 2'd0, 1'b1, 1'b0);   // R5 12FF then 1200
      do_access(16'h1201, 1'b1, 8'hFF, 16'h0, 2'd0, 1'b0, 1'b0);   // R6 -> 001300
      do_access(16'h3400, 1'b1, 8'h20, 16'h01F0, 2'd1, 1'b1, 1'b0); // R5 indexed -> 3410, 3411
      do_access(16'hFFF0, 1'b0, 8'h05, 16'h0020, 2'd1, 1'b0, 1'b0); // R4 -> 000015
      do_access(16'hFFFF, 1'b0, 8'h01, 16'h0, 2'd2, 1'b0, 1'b0);    // R4/R11 carry out of FFFF
      do_access(16'h0000, 1'b0, 8'hFF, 16'h0, 2'd0, 1'b1, 1'b1);    // R4 native no wrap, noisy

      // constrained random
      for (int i = 0; i < 400; i++) begin
         logic [15:0] d;
         d = 16'($urandom);
         if ($urandom_range(0, 1) == 0) d[7:0] = 8'h00;
         do_access(d, 1'($urandom), 8'($urandom), 16'($urandom), 2'($urandom), 1'($urandom),
                   ($urandom_range(0, 3) == 0));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule